// File: doc/BRIEF.md
# Cipher Round Helper Execute Slice

This block sits next to the integer ALU of a small 32-bit processor with a 16-entry register file. It looks at every instruction word. It claims two register-register instructions in the custom-0 major opcode, which speed up the add-rotate-xor rounds of a lightweight 64-bit block cipher.

One instruction rotates the first source operand right by eight bits and adds the second operand, modulo 2^32. The other rotates the first operand left by three bits and XORs it with the second operand. The slice has no state and finishes within the cycle.

It outputs a claim flag, the result, the destination index and a write enable. Any word it does not claim leaves the claim flag low, so the base ALU or the illegal-instruction trap takes it.

Top module: `spk_exec`

## Requirements
- R1: The claim flag `hit_o` can be high only when instruction bits [6:0] equal 7'h0B.
- R2: With bits [6:0] = 7'h0B and bits [14:12] = 3'b000, `hit_o` is high and `result_o` equals (`src_a_i` rotated right by 8) + `src_b_i`, modulo 2^32.
- R3: With bits [6:0] = 7'h0B and bits [14:12] = 3'b001, `hit_o` is high and `result_o` equals (`src_a_i` rotated left by 3) XOR `src_b_i`.
- R4: With bits [6:0] = 7'h0B and any other value in bits [14:12], `hit_o` is low.
- R5: Bits [31:25] of the instruction have no effect on any output.
- R6: `rd_idx_o` equals instruction bits [10:7].
- R7: `bad_reg_o` is high exactly when `hit_o` is high and at least one of bits 11, 19 or 24 (the top bit of the destination, first-source and second-source fields) is set.
- R8: `wr_en_o` is high exactly when `hit_o` is high, `bad_reg_o` is low and bits [10:7] are non-zero. A destination of register 0 is never written.
- R9: When `hit_o` is low, `result_o` is zero and `wr_en_o` and `bad_reg_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under decode |
| src_a_i | input | 32 | First source operand value |
| src_b_i | input | 32 | Second source operand value |
| hit_o | output | 1 | Instruction is claimed by this slice |
| result_o | output | 32 | Computed result, zero when not claimed |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| bad_reg_o | output | 1 | Claimed instruction names a register above x15 |

## Verification
The bench builds the slice with its defaults: a 32-bit datapath, 4-bit register indices, rotate amounts of 8 and 3, and major opcode 7'h0B. With these values the fixed test vectors for the cipher round apply as they are. The carry out of bit 31 in the sum is checked by a directed wrap case.

Random instruction words are biased toward the custom opcode, so all eight funct3 codes and all funct7 values are drawn. Setting the top bit of each register field reaches every illegal-register case. Directed words with funct7 flipped show that the outputs do not change.

// File: rtl/spk_pkg.sv
package spk_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned OPC_LSB   = 0;
  localparam int unsigned OPC_W     = 7;
  localparam int unsigned RD_LSB    = 7;
  localparam int unsigned F3_LSB    = 12;
  localparam int unsigned F3_W      = 3;
  localparam int unsigned RS1_LSB   = 15;
  localparam int unsigned RS2_LSB   = 20;
  localparam int unsigned FIELD_W   = 5;

  typedef enum logic [F3_W-1:0] {
    OP_ROR_ADD = 3'b000,
    OP_ROL_XOR = 3'b001
  } spk_op_e;

endpackage

// File: rtl/spk_rotator.sv
module spk_rotator #(
  parameter int unsigned W      = 32,
  parameter int unsigned AMT    = 8,
  parameter bit          TO_LEFT = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned SH = AMT % W;

  generate
    if (SH == 0) begin : g_pass
      assign dout = din;
    end else if (TO_LEFT) begin : g_left
      assign dout = {din[W-SH-1:0], din[W-1:W-SH]};
    end else begin : g_right
      assign dout = {din[SH-1:0], din[W-1:SH]};
    end
  endgenerate

endmodule

// File: rtl/spk_decode.sv
module spk_decode
  import spk_pkg::*;
#(
  parameter int unsigned        REG_W  = 4,
  parameter logic [OPC_W-1:0]   OPCODE = 7'h0B
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               hit,
  output spk_op_e            op_sel,
  output logic [REG_W-1:0]   rd_idx,
  output logic               bad_reg,
  output logic               wr_en
);

  logic [F3_W-1:0] f3;
  logic            opc_ok;
  logic            f3_ok;
  logic            hi_bits;

  assign f3     = instr[F3_LSB +: F3_W];
  assign opc_ok = (instr[OPC_LSB +: OPC_W] == OPCODE);
  assign rd_idx = instr[RD_LSB +: REG_W];

  always_comb begin
    f3_ok  = 1'b0;
    op_sel = OP_ROR_ADD;
    case (f3)
      OP_ROR_ADD: begin f3_ok = 1'b1; op_sel = OP_ROR_ADD; end
      OP_ROL_XOR: begin f3_ok = 1'b1; op_sel = OP_ROL_XOR; end
      default:    begin f3_ok = 1'b0; op_sel = OP_ROR_ADD; end
    endcase
  end

  generate
    if (REG_W < FIELD_W) begin : g_narrow
      assign hi_bits = (|instr[RD_LSB  + REG_W +: FIELD_W-REG_W])
                     | (|instr[RS1_LSB + REG_W +: FIELD_W-REG_W])
                     | (|instr[RS2_LSB + REG_W +: FIELD_W-REG_W]);
    end else begin : g_full
      assign hi_bits = 1'b0;
    end
  endgenerate

  assign hit     = opc_ok & f3_ok;
  assign bad_reg = hit & hi_bits;
  assign wr_en   = hit & ~hi_bits & (|rd_idx);

  logic unused_fields;
  assign unused_fields = ^{instr[31:25], instr[RS1_LSB +: REG_W], instr[RS2_LSB +: REG_W]};

endmodule

// File: rtl/spk_datapath.sv
module spk_datapath
  import spk_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned ROR_AMT = 8,
  parameter int unsigned ROL_AMT = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  spk_op_e      op_sel,
  input  logic         hit,
  output logic [W-1:0] res
);

  logic [W-1:0] a_ror;
  logic [W-1:0] a_rol;
  logic [W-1:0] sum_v;
  logic [W-1:0] xor_v;

  spk_rotator #(.W(W), .AMT(ROR_AMT), .TO_LEFT(1'b0)) u_ror (.din(a), .dout(a_ror));
  spk_rotator #(.W(W), .AMT(ROL_AMT), .TO_LEFT(1'b1)) u_rol (.din(a), .dout(a_rol));

  assign sum_v = a_ror + b;
  assign xor_v = a_rol ^ b;

  always_comb begin
    res = '0;
    if (hit) begin
      res = (op_sel == OP_ROL_XOR) ? xor_v : sum_v;
    end
  end

endmodule

// File: rtl/spk_exec.sv
module spk_exec
  import spk_pkg::*;
#(
  parameter int unsigned      XLEN    = 32,
  parameter int unsigned      REG_W   = 4,
  parameter int unsigned      ROR_AMT = 8,
  parameter int unsigned      ROL_AMT = 3,
  parameter logic [6:0]       OPCODE  = 7'h0B
) (
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  output logic             hit_o,
  output logic [XLEN-1:0]  result_o,
  output logic [REG_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic             bad_reg_o
);

  spk_op_e op_sel;

  spk_decode #(.REG_W(REG_W), .OPCODE(OPCODE)) u_dec (
    .instr   (instr_i),
    .hit     (hit_o),
    .op_sel  (op_sel),
    .rd_idx  (rd_idx_o),
    .bad_reg (bad_reg_o),
    .wr_en   (wr_en_o)
  );

  spk_datapath #(.W(XLEN), .ROR_AMT(ROR_AMT), .ROL_AMT(ROL_AMT)) u_dp (
    .a      (src_a_i),
    .b      (src_b_i),
    .op_sel (op_sel),
    .hit    (hit_o),
    .res    (result_o)
  );

endmodule

// File: rtl/spk_exec_chk.sv
module spk_exec_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned ROR_AMT = 8,
  parameter int unsigned ROL_AMT = 3,
  parameter logic [6:0]  OPCODE  = 7'h0B
) (
  input logic [31:0]      instr_i,
  input logic [XLEN-1:0]  src_a_i,
  input logic [XLEN-1:0]  src_b_i,
  input logic             hit_o,
  input logic [XLEN-1:0]  result_o,
  input logic [REG_W-1:0] rd_idx_o,
  input logic             wr_en_o,
  input logic             bad_reg_o
);

  logic [XLEN-1:0] ref_sum;
  logic [XLEN-1:0] ref_xor;

  always_comb begin
    ref_sum = ((src_a_i >> ROR_AMT) | (src_a_i << (XLEN - ROR_AMT))) + src_b_i;
    ref_xor = ((src_a_i << ROL_AMT) | (src_a_i >> (XLEN - ROL_AMT))) ^ src_b_i;
  end

  always_comb begin
    if (hit_o) begin
      p_opcode_r1: assert (instr_i[6:0] == OPCODE);
      p_funct3_r4: assert (instr_i[14:13] == 2'b00);
    end
    if (hit_o && instr_i[12] == 1'b0) begin
      p_sum_r2: assert (result_o == ref_sum);
    end
    if (hit_o && instr_i[12] == 1'b1) begin
      p_xor_r3: assert (result_o == ref_xor);
    end
    p_rd_r6: assert (rd_idx_o == instr_i[7 +: REG_W]);
    if (bad_reg_o) begin
      p_bad_claimed_r7: assert (hit_o);
    end
    if (wr_en_o) begin
      p_wr_legal_r8: assert (hit_o && !bad_reg_o && rd_idx_o != '0);
    end
    if (!hit_o) begin
      p_idle_r9: assert (result_o == '0 && !wr_en_o && !bad_reg_o);
    end
  end

endmodule

bind spk_exec spk_exec_chk #(
  .XLEN(XLEN), .REG_W(REG_W), .ROR_AMT(ROR_AMT), .ROL_AMT(ROL_AMT), .OPCODE(OPCODE)
) u_chk (.*);

// File: tb/sim_spk_exec.sv
`timescale 1ns/1ps
module sim_spk_exec;

  logic        clk;
  logic [31:0] instr;
  logic [31:0] a;
  logic [31:0] b;
  logic        hit;
  logic [31:0] res;
  logic [3:0]  rd;
  logic        wen;
  logic        bad;

  int n_chk;
  int n_fail;
  bit done;

  spk_exec u0 (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .hit_o(hit), .result_o(res), .rd_idx_o(rd), .wr_en_o(wen), .bad_reg_o(bad)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] rot(input logic [31:0] v, input int n, input bit left);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) begin
      if (left) o[(i + n) % 32] = v[i];
      else      o[i] = v[(i + n) % 32];
    end
    return o;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rdf, input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rdf, opc};
  endfunction

  task automatic apply_and_check(input logic [31:0] iw, input logic [31:0] va, input logic [31:0] vb);
    logic        e_hit;
    logic        e_bad;
    logic        e_wen;
    logic [31:0] e_res;
    @(posedge clk); #1;
    instr = iw; a = va; b = vb;
    @(negedge clk);
    e_hit = (iw[6:0] == 7'h0B) && (iw[14:12] == 3'b000 || iw[14:12] == 3'b001);
    e_res = 32'h0;
    if (e_hit && iw[14:12] == 3'b000) e_res = rot(va, 8, 1'b0) + vb;
    if (e_hit && iw[14:12] == 3'b001) e_res = rot(va, 3, 1'b1) ^ vb;
    e_bad = e_hit && (iw[11] || iw[19] || iw[24]);
    e_wen = e_hit && !e_bad && (iw[10:7] != 4'd0);
    check("R1/R4", "hit", {31'd0, hit}, {31'd0, e_hit});
    check(iw[12] ? "R3" : "R2", "result R9", res, e_res);
    check("R6", "rd", {28'd0, rd}, {28'd0, iw[10:7]});
    check("R7", "bad_reg", {31'd0, bad}, {31'd0, e_bad});
    check("R8", "wr_en", {31'd0, wen}, {31'd0, e_wen});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] iw;
    logic [31:0] s0;
    logic [31:0] s1;
    n_chk = 0; n_fail = 0; done = 0;
    instr = 32'h0; a = 32'h0; b = 32'h0;
    s0 = $urandom(32'h5EC0_0D11);

    // idle state with all-zero inputs: R9
    @(negedge clk);
    check("R9", "idle hit", {31'd0, hit}, 32'd0);
    check("R9", "idle result", res, 32'd0);

    // R2 directed values and carry wrap
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b000, 5'd5, 7'h0B), 32'h12345678, 32'h00000001);
    check("R2", "sum value", res, 32'h78123457);
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b000, 5'd5, 7'h0B), 32'h000000FF, 32'h01000000);
    check("R2", "sum wrap", res, 32'h00000000);
    // R3 directed
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b001, 5'd6, 7'h0B), 32'h80000001, 32'h00000000);
    check("R3", "xor value", res, 32'h0000000C);
    // R4: funct3 = 010 not claimed
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b010, 5'd6, 7'h0B), 32'hFFFFFFFF, 32'h1);
    check("R4", "f3 010 hit", {31'd0, hit}, 32'd0);
    // R1: other opcode
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b000, 5'd6, 7'h33), 32'h1234, 32'h1);
    check("R1", "opcode 33 hit", {31'd0, hit}, 32'd0);
    // R8: rd = x0 dropped
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b000, 5'd0, 7'h0B), 32'h1, 32'h1);
    check("R8", "rd0 wr_en", {31'd0, wen}, 32'd0);
    // R7: each upper register bit
    apply_and_check(mk(7'd0, 5'd2, 5'd1, 3'b001, 5'd16, 7'h0B), 32'h1, 32'h1);
    check("R7", "rd bit4", {31'd0, bad}, 32'd1);
    apply_and_check(mk(7'd0, 5'd2, 5'd17, 3'b001, 5'd3, 7'h0B), 32'h1, 32'h1);
    check("R7", "rs1 bit4", {31'd0, bad}, 32'd1);
    apply_and_check(mk(7'd0, 5'd18, 5'd1, 3'b000, 5'd3, 7'h0B), 32'h1, 32'h1);
    check("R7", "rs2 bit4", {31'd0, bad}, 32'd1);
    // R5: funct7 flipped gives identical outputs
    apply_and_check(mk(7'd0, 5'd9, 5'd4, 3'b001, 5'd7, 7'h0B), 32'hDEADBEEF, 32'hCAFEF00D);
    s1 = res;
    apply_and_check(mk(7'h7F, 5'd9, 5'd4, 3'b001, 5'd7, 7'h0B), 32'hDEADBEEF, 32'hCAFEF00D);
    check("R5", "funct7 ignored result", res, s1);
    check("R5", "funct7 ignored hit", {31'd0, hit}, 32'd1);

    // constrained random
    for (int k = 0; k < 600; k++) begin
      iw = $urandom();
      if ($urandom_range(3) != 0) iw[6:0] = 7'h0B;
      if ($urandom_range(3) != 0) iw[14:13] = 2'b00;
      if ($urandom_range(3) != 0) begin iw[11] = 1'b0; iw[19] = 1'b0; iw[24] = 1'b0; end
      apply_and_check(iw, $urandom(), $urandom());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule